// File: doc/BRIEF.md
# UDP Receive Header Parser

This block sits on the receive path between an IPv4 layer and a UDP consumer. The IPv4 layer gives it two things. One is a byte stream of the IP payload, with a valid flag and a last flag. The other is a sideband that carries a frame-start level, a header-valid flag, the protocol number and the source address. The parser accepts only frames whose protocol number marks them as UDP. It stays silent for the whole of any other frame.

For an accepted frame, the parser takes the first eight payload bytes as the UDP header. It presents the source port, the destination port and the user-data length, and copies the source address across from the sideband. It then forwards every later byte with a valid flag. The last flag travels on the same byte it arrived with. A start level is held high while the user data is being delivered. When a frame ends, the data, valid, last, start and header-valid outputs all fall back to zero.

Top module: `udp_rx_parser`

## Requirements
- R1: While rst_ni is low, udp_start_o, hdr_valid_o, out_valid_o and out_last_o are 0, and out_data_o and all header outputs are 0.
- R2: A frame is accepted only when ip_proto_i equals 0x11 at frame start. For any other value, udp_start_o, hdr_valid_o, out_valid_o and out_last_o stay 0 until that frame ends.
- R3: The header bytes are read in big-endian order. Bytes 0-1 are the source port and bytes 2-3 the destination port. Bytes 4-5 are the length. Bytes 6-7 are the checksum, which is consumed but not reported. hdr_src_ip_o takes the value of ip_src_i, and all header outputs hold their values while hdr_valid_o is high.
- R4: Header bytes are counted only on cycles with in_valid_i high. hdr_valid_o rises on the clock edge that accepts the eighth header byte, so it is visible in the following cycle.
- R5: hdr_len_o equals the length field minus 8. It is clamped to 0 when the field is below 8.
- R6: Each byte after the header is forwarded on out_data_o with out_valid_o one cycle after it is accepted. udp_start_o rises with the first forwarded byte and stays high through the last one.
- R7: out_last_o is high on exactly the forwarded byte that carried in_last_i.
- R8: In the cycle after the last byte is forwarded, out_data_o is 0x00 and out_valid_o, out_last_o, udp_start_o and hdr_valid_o are all 0. out_data_o is 0x00 whenever out_valid_o is low.
- R9: A frame begins on the first clock edge at which ip_start_i is high after being low, with ip_hdr_valid_i high. Bytes presented outside a frame produce no output.
- R10: A frame ends on in_last_i or when ip_start_i falls, whichever comes first. The next frame is parsed correctly, whether the one before it was rejected or cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ip_start_i | input | 1 | High for the duration of an IP frame |
| ip_hdr_valid_i | input | 1 | IP sideband fields are valid |
| ip_proto_i | input | 8 | IP protocol number |
| ip_src_i | input | 32 | IP source address |
| in_data_i | input | 8 | IP payload byte |
| in_valid_i | input | 1 | Payload byte valid |
| in_last_i | input | 1 | Final payload byte of the frame |
| udp_start_o | output | 1 | High while user data is delivered |
| hdr_valid_o | output | 1 | UDP header outputs are valid |
| hdr_src_ip_o | output | 32 | Source address of the datagram |
| hdr_src_port_o | output | 16 | UDP source port |
| hdr_dst_port_o | output | 16 | UDP destination port |
| hdr_len_o | output | 16 | User-data length in bytes |
| out_data_o | output | 8 | Forwarded user-data byte |
| out_valid_o | output | 1 | Forwarded byte valid |
| out_last_o | output | 1 | Forwarded byte is the final one |

## Verification
Every output is a register, so each result appears one clock edge after the input that causes it. The frame-start rise moves the parser into header mode at the next edge. The eighth accepted header byte shows up as hdr_valid_o, with the captured fields, one cycle later. Each user byte, and its last flag, comes out the cycle after it is accepted, and the clear-down comes one cycle after the last byte. The bench drives inputs on the falling edge and samples on the next falling edge, which is exactly one rising edge later. Each check therefore compares against the value due from the previous cycle's stimulus. Idle gaps inside the header shift every later check by the same number of cycles.

// File: rtl/udp_rx_pkg.sv
package udp_rx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2,
    ST_DROP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/udp_rx_fsm.sv
module udp_rx_fsm
  import udp_rx_pkg::*;
#(
  parameter int          HDR_BYTES = 8,
  parameter logic [7:0]  UDP_PROTO = 8'h11,
  localparam int         CNT_W     = $clog2(HDR_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ip_start_i,
  input  logic             ip_hdr_valid_i,
  input  logic [7:0]       ip_proto_i,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  output logic             idle_o,
  output logic             hdr_take_o,
  output logic             hdr_done_o,
  output logic [CNT_W-1:0] hdr_idx_o,
  output logic             pay_take_o
);
  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             start_q;
  logic             start_rise;

  assign start_rise = ip_start_i & ~start_q;
  assign idle_o     = (state_q == ST_IDLE);
  assign hdr_take_o = (state_q == ST_HDR) & ip_start_i & in_valid_i;
  // a last flag inside the header truncates the frame: no header-valid
  assign hdr_done_o = hdr_take_o & ~in_last_i & (cnt_q == CNT_W'(HDR_BYTES - 1));
  assign pay_take_o = (state_q == ST_PAY) & ip_start_i & in_valid_i;
  assign hdr_idx_o  = cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_rise && ip_hdr_valid_i)
          state_d = (ip_proto_i == UDP_PROTO) ? ST_HDR : ST_DROP;
      end
      ST_HDR: begin
        if (!ip_start_i)                   state_d = ST_IDLE;
        else if (hdr_take_o && in_last_i)  state_d = ST_IDLE;
        else if (hdr_done_o)               state_d = ST_PAY;
      end
      ST_PAY: begin
        if (!ip_start_i)                   state_d = ST_IDLE;
        else if (pay_take_o && in_last_i)  state_d = ST_IDLE;
      end
      ST_DROP: begin
        if (!ip_start_i || (in_valid_i && in_last_i)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= ip_start_i;
      if (state_q == ST_IDLE) cnt_q <= '0;
      else if (hdr_take_o)    cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/udp_rx_hdr_cap.sv
module udp_rx_hdr_cap
  import udp_rx_pkg::*;
#(
  parameter int  HDR_BYTES   = 8,
  parameter int  ADDR_W      = 32,
  parameter int  PORT_W      = 16,
  localparam int CNT_W       = $clog2(HDR_BYTES),
  localparam int FIELD_BYTES = 3 * PORT_W / BYTE_W,
  localparam int SR_W        = FIELD_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_take_i,
  input  logic              hdr_done_i,
  input  logic [CNT_W-1:0]  hdr_idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] ip_src_i,
  output logic [ADDR_W-1:0] src_ip_o,
  output logic [PORT_W-1:0] src_port_o,
  output logic [PORT_W-1:0] dst_port_o,
  output logic [PORT_W-1:0] len_o
);
  logic [SR_W-1:0]   sr_q;
  logic [PORT_W-1:0] len_field;

  // only the port and length bytes are kept; checksum bytes just advance the count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else if (hdr_take_i && (hdr_idx_i < CNT_W'(FIELD_BYTES)))
      sr_q <= {sr_q[SR_W-BYTE_W-1:0], byte_i};
  end

  assign len_field = sr_q[PORT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_ip_o   <= '0;
      src_port_o <= '0;
      dst_port_o <= '0;
      len_o      <= '0;
    end else if (hdr_done_i) begin
      src_ip_o   <= ip_src_i;
      src_port_o <= sr_q[SR_W-1 -: PORT_W];
      dst_port_o <= sr_q[SR_W-PORT_W-1 -: PORT_W];
      len_o      <= (len_field < PORT_W'(HDR_BYTES)) ? '0 : len_field - PORT_W'(HDR_BYTES);
    end
  end
endmodule

// File: rtl/udp_rx_out_stage.sv
module udp_rx_out_stage
  import udp_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              hdr_done_i,
  input  logic              pay_take_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  output logic              start_o,
  output logic              hdr_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_data_o  <= '0;
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      start_o     <= 1'b0;
      hdr_valid_o <= 1'b0;
    end else begin
      out_valid_o <= pay_take_i;
      out_data_o  <= pay_take_i ? in_data_i : '0;
      out_last_o  <= pay_take_i & in_last_i;
      if (pay_take_i)  start_o <= 1'b1;
      else if (idle_i) start_o <= 1'b0;
      if (hdr_done_i)  hdr_valid_o <= 1'b1;
      else if (idle_i) hdr_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/udp_rx_parser.sv
module udp_rx_parser
  import udp_rx_pkg::*;
#(
  parameter int         HDR_BYTES = 8,
  parameter int         ADDR_W    = 32,
  parameter int         PORT_W    = 16,
  parameter logic [7:0] UDP_PROTO = 8'h11,
  localparam int        CNT_W     = $clog2(HDR_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ip_start_i,
  input  logic              ip_hdr_valid_i,
  input  logic [7:0]        ip_proto_i,
  input  logic [ADDR_W-1:0] ip_src_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  output logic              udp_start_o,
  output logic              hdr_valid_o,
  output logic [ADDR_W-1:0] hdr_src_ip_o,
  output logic [PORT_W-1:0] hdr_src_port_o,
  output logic [PORT_W-1:0] hdr_dst_port_o,
  output logic [PORT_W-1:0] hdr_len_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o
);
  logic             idle;
  logic             hdr_take;
  logic             hdr_done;
  logic [CNT_W-1:0] hdr_idx;
  logic             pay_take;

  udp_rx_fsm #(
    .HDR_BYTES (HDR_BYTES),
    .UDP_PROTO (UDP_PROTO)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ip_start_i     (ip_start_i),
    .ip_hdr_valid_i (ip_hdr_valid_i),
    .ip_proto_i     (ip_proto_i),
    .in_valid_i     (in_valid_i),
    .in_last_i      (in_last_i),
    .idle_o         (idle),
    .hdr_take_o     (hdr_take),
    .hdr_done_o     (hdr_done),
    .hdr_idx_o      (hdr_idx),
    .pay_take_o     (pay_take)
  );

  udp_rx_hdr_cap #(
    .HDR_BYTES (HDR_BYTES),
    .ADDR_W    (ADDR_W),
    .PORT_W    (PORT_W)
  ) u_hdr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hdr_take_i (hdr_take),
    .hdr_done_i (hdr_done),
    .hdr_idx_i  (hdr_idx),
    .byte_i     (in_data_i),
    .ip_src_i   (ip_src_i),
    .src_ip_o   (hdr_src_ip_o),
    .src_port_o (hdr_src_port_o),
    .dst_port_o (hdr_dst_port_o),
    .len_o      (hdr_len_o)
  );

  udp_rx_out_stage u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idle_i      (idle),
    .hdr_done_i  (hdr_done),
    .pay_take_i  (pay_take),
    .in_data_i   (in_data_i),
    .in_last_i   (in_last_i),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .start_o     (udp_start_o),
    .hdr_valid_o (hdr_valid_o)
  );
endmodule

// File: rtl/udp_rx_parser_chk.sv
module udp_rx_parser_chk #(
  parameter int PORT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              udp_start_o,
  input logic              hdr_valid_o,
  input logic [PORT_W-1:0] hdr_src_port_o,
  input logic [PORT_W-1:0] hdr_len_o,
  input logic [7:0]        out_data_o,
  input logic              out_valid_o,
  input logic              out_last_o
);
  AST_LAST_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o); // R7

  AST_DATA_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (out_data_o == 8'h00)); // R8

  AST_PAY_AFTER_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (hdr_valid_o && udp_start_o)); // R6

  AST_LAST_THEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |=> (!out_valid_o && !udp_start_o && !hdr_valid_o)); // R8

  AST_HDR_BEFORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hdr_valid_o) |-> !udp_start_o); // R4

  AST_FIELDS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_o && $past(hdr_valid_o)) |-> ($stable(hdr_src_port_o) && $stable(hdr_len_o))); // R3
endmodule

bind udp_rx_parser udp_rx_parser_chk #(.PORT_W(PORT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .udp_start_o    (udp_start_o),
  .hdr_valid_o    (hdr_valid_o),
  .hdr_src_port_o (hdr_src_port_o),
  .hdr_len_o      (hdr_len_o),
  .out_data_o     (out_data_o),
  .out_valid_o    (out_valid_o),
  .out_last_o     (out_last_o)
);

// File: tb/tb_udp_rx_parser.sv
`timescale 1ns/1ps
module tb_udp_rx_parser;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ip_start_i = 1'b0;
  logic        ip_hdr_valid_i = 1'b0;
  logic [7:0]  ip_proto_i = '0;
  logic [31:0] ip_src_i = '0;
  logic [7:0]  in_data_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_last_i = 1'b0;
  logic        udp_start_o, hdr_valid_o, out_valid_o, out_last_o;
  logic [31:0] hdr_src_ip_o;
  logic [15:0] hdr_src_port_o, hdr_dst_port_o, hdr_len_o;
  logic [7:0]  out_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  udp_rx_parser dut (.*);

  // {proto, src ip, src port, dst port, length field, payload bytes, seed}
  localparam int NV = 5;
  localparam logic [103:0] VEC [NV] = '{
    {8'h11, 32'hc0a80501, 16'h1498, 16'h8724, 16'h000b, 8'd3, 8'h41},
    {8'h11, 32'hc0a80501, 16'h7623, 16'h0365, 16'h000d, 8'd5, 8'h17},
    {8'h12, 32'hc0a80501, 16'h7623, 16'h0365, 16'h000d, 8'd5, 8'h17},
    {8'h11, 32'h0a000002, 16'h1498, 16'h8724, 16'h000b, 8'd3, 8'h41},
    {8'h11, 32'hac100a0f, 16'hffff, 16'h0001, 16'h0010, 8'd8, 8'h90}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_frame(input logic [7:0] proto, input logic [31:0] src);
    @(negedge clk_i);
    ip_start_i = 1'b1; ip_hdr_valid_i = 1'b1; ip_proto_i = proto; ip_src_i = src;
    @(negedge clk_i);
  endtask

  task automatic drive_byte(input logic [7:0] b, input logic last);
    in_valid_i = 1'b1; in_data_i = b; in_last_i = last;
    @(negedge clk_i);
  endtask

  task automatic idle_cycle();
    in_valid_i = 1'b0; in_last_i = 1'b0; in_data_i = 8'hee;
    @(negedge clk_i);
  endtask

  task automatic end_frame();
    ip_start_i = 1'b0; ip_hdr_valid_i = 1'b0; in_valid_i = 1'b0; in_last_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic run_frame(input logic [103:0] v, input int gap, input string tag);
    logic [7:0]  proto = v[103:96];
    logic [31:0] src = v[95:64];
    logic [15:0] sp = v[63:48], dp = v[47:32], lf = v[31:16];
    int          np = int'(v[15:8]);
    logic [7:0]  seed = v[7:0];
    logic        acc = (proto == 8'h11);
    logic [7:0]  hb [8];
    logic [15:0] exp_len = (lf < 16'd8) ? 16'd0 : lf - 16'd8;
    hb = '{sp[15:8], sp[7:0], dp[15:8], dp[7:0], lf[15:8], lf[7:0], 8'h5a, 8'ha5};
    start_frame(proto, src);
    for (int i = 0; i < 8; i++) begin
      drive_byte(hb[i], 1'b0);
      if (i < 7) chk({tag, " R4 hdr_valid early"}, 32'(hdr_valid_o), 32'd0);
      if (i == 2) repeat (gap) idle_cycle();
    end
    chk({tag, " R2/R4 hdr_valid"}, 32'(hdr_valid_o), 32'(acc));
    chk({tag, " R6 start before data"}, 32'(udp_start_o), 32'd0);
    if (acc) begin
      chk({tag, " R3 src ip"}, hdr_src_ip_o, src);
      chk({tag, " R3 src port"}, 32'(hdr_src_port_o), 32'(sp));
      chk({tag, " R3 dst port"}, 32'(hdr_dst_port_o), 32'(dp));
      chk({tag, " R5 length"}, 32'(hdr_len_o), 32'(exp_len));
    end
    for (int i = 0; i < np; i++) begin
      logic [7:0] b = seed + 8'(i * 17);
      drive_byte(b, i == np - 1);
      chk({tag, " R2/R6 out_valid"}, 32'(out_valid_o), 32'(acc));
      chk({tag, " R6 out_data"}, 32'(out_data_o), acc ? 32'(b) : 32'd0);
      chk({tag, " R7 out_last"}, 32'(out_last_o), 32'(acc && (i == np - 1)));
      chk({tag, " R6 udp_start"}, 32'(udp_start_o), 32'(acc));
    end
    end_frame();
    chk({tag, " R8 data cleared"}, 32'(out_data_o), 32'd0);
    chk({tag, " R8 valid/last/start/hdr cleared"},
        {28'd0, out_valid_o, out_last_o, udp_start_o, hdr_valid_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset flags", {28'd0, out_valid_o, out_last_o, udp_start_o, hdr_valid_o}, 32'd0);
    chk("R1 reset data", 32'(out_data_o), 32'd0);
    chk("R1 reset header", 32'(hdr_src_port_o | hdr_dst_port_o | hdr_len_o) | hdr_src_ip_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int k = 0; k < NV; k++) run_frame(VEC[k], (k == 4) ? 3 : 0, $sformatf("vec%0d", k));

    // R9: bytes with no frame open are ignored
    for (int i = 0; i < 3; i++) begin
      drive_byte(8'h33 + 8'(i), i == 2);
      chk("R9 stray byte out_valid", 32'(out_valid_o), 32'd0);
      chk("R9 stray byte start", 32'(udp_start_o), 32'd0);
    end
    idle_cycle();

    // R10: start drops mid-header, then a clean frame follows
    start_frame(8'h11, 32'h01020304);
    drive_byte(8'h11, 1'b0);
    drive_byte(8'h22, 1'b0);
    drive_byte(8'h33, 1'b0);
    end_frame();
    chk("R10 aborted frame quiet", {28'd0, out_valid_o, out_last_o, udp_start_o, hdr_valid_o}, 32'd0);
    run_frame({8'h11, 32'h01020304, 16'h0102, 16'h0304, 16'h000a, 8'd2, 8'h70}, 0, "after_abort R10");

    // R5: length field below header size clamps to zero
    run_frame({8'h11, 32'h0b0b0b0b, 16'h0bad, 16'h0f00, 16'h0005, 8'd2, 8'h01}, 1, "clamp R5");

    // R1: reset in the middle of the user data
    start_frame(8'h11, 32'h99887766);
    for (int i = 0; i < 8; i++) drive_byte(8'h10 + 8'(i), 1'b0);
    drive_byte(8'hc3, 1'b0);
    chk("R6 mid-frame valid", 32'(out_valid_o), 32'd1);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset flags", {28'd0, out_valid_o, out_last_o, udp_start_o, hdr_valid_o}, 32'd0);
    chk("R1 async reset data", 32'(out_data_o), 32'd0);
    end_frame();
    rst_ni = 1'b1;
    run_frame(VEC[1], 0, "post_reset R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule